// File: doc/BRIEF.md
# Data Link Receive Byte Collector

This block takes a serial stream of data link bits (or framing-pattern bits) and packs them into bytes. Each time the input strobe is high, one bit is taken from the bit input. After eight accepted bits the byte is copied into a holding register that software reads. A buffer-full status flag is raised at the same time. Software must read the byte before the next one completes, because the next byte overwrites it. At the nominal line rate of one bit per 250 us, that gives 2 ms.

Every completed byte is compared with two programmable match bytes. A hit on either one raises a match status flag. Software can therefore leave the stream alone until a pattern of interest shows up. Both status flags are sticky and are cleared by writing 1 to them. Each flag has an enable bit that lets it pull the active-low interrupt output down.

An optional zero destuffer works on the bits as they arrive. When it is on, a 0 that comes directly after exactly five 1s is dropped before collection, so that user data cannot imitate a flag.

Top module: `dl_rx_collector`

Register map (address: contents):
- 0: received byte, read only.
- 1: match byte A, read and write.
- 2: match byte B, read and write.
- 3: control, bit 0 enables destuffing.
- 4: interrupt enables, bit 0 for buffer-full, bit 1 for match.
- 5: status, bit 0 is buffer-full and bit 1 is match. Writing 1 to a bit clears it.
- Addresses 6 and 7 read as 0.

## Requirements
- R1: Accepted bits are collected least significant bit first: the first accepted bit of a byte ends up in bit 0 of the received byte (address 0), and the eighth in bit 7. The received byte changes on the clock edge that takes the eighth bit.
- R2: On the edge that completes a byte, status bit 0 (buffer-full) becomes 1.
- R3: If a completed byte has not been read, the next completed byte replaces it at address 0.
- R4: On completion, status bit 1 (match) becomes 1 when the byte equals match byte A (address 1) or match byte B (address 2). Otherwise the match flag keeps its previous value.
- R5: `irq_n` is 0 exactly when some status bit is 1 and its enable bit at address 4 (bit 0 for buffer-full, bit 1 for match) is also 1. Otherwise `irq_n` is 1.
- R6: With control bit 0 set, a 0 that arrives directly after exactly five consecutive 1s is dropped. It is not collected and does not count toward the eight bits.
- R7: A run of six or more 1s is collected unchanged. The 0 that follows such a run is kept. Any collected or dropped 0 restarts the count of consecutive 1s.
- R8: With control bit 0 clear, every strobed bit is collected, including a 0 after five 1s.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a byte completes on the same edge as a clearing write, the flag that is being set stays 1.
- R10: Reset clears the bit collection state, the count of consecutive 1s, the received byte, both status flags, the match bytes, the control register and the enables, and leaves `irq_n` at 1.
- R11: Match bytes, control and enables read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial data link bit |
| bit_vld | input | 1 | Strobe: take `bit_in` on this edge |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check the following on every cycle:
- the link between enabled status flags and `irq_n`;
- that a completion edge always leaves buffer-full set;
- that a dropped stuffed zero freezes the bit count;
- that a clearing write with no completion removes the flag;
- that the consecutive-ones count stays within its cap.

Some behaviours need stimulus sequences and only the bench scenarios show them:
- the bit order inside the byte;
- equality against each match byte;
- the overwrite of an unread byte;
- the exact position of dropped zeros against long runs of 1s.

The bench compares these against its own model over a long random bit stream. Directed sequences cover the five-ones and six-ones boundaries and a clearing write on the same edge as a completion.

// File: rtl/dl_rx_collector.sv
module dl_rx_collector #(
  parameter int DW         = 8,
  parameter int AW         = 3,
  parameter int ONES_LIMIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          bit_vld,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_n
);
  localparam int CW = $clog2(DW);
  localparam int OW = $clog2(ONES_LIMIT + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [OW-1:0] RUN_AT   = OW'(ONES_LIMIT);
  localparam logic [OW-1:0] RUN_CAP  = OW'(ONES_LIMIT + 1);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_MA   = AW'(1);
  localparam logic [AW-1:0] A_MB   = AW'(2);
  localparam logic [AW-1:0] A_CTRL = AW'(3);
  localparam logic [AW-1:0] A_MASK = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);

  logic [DW-1:0] sr_q, hold_q, ma_q, mb_q;
  logic [CW-1:0] cnt_q;
  logic [OW-1:0] ones_q;
  logic          dstf_q;
  logic [1:0]    mask_q, stat_q;

  logic          drop, take, done, hit;
  logic [DW-1:0] sr_nx;
  logic [1:0]    clr, set;

  assign drop  = bit_vld && dstf_q && (ones_q == RUN_AT) && !bit_in;
  assign take  = bit_vld && !drop;
  assign sr_nx = {bit_in, sr_q[DW-1:1]};
  assign done  = take && (cnt_q == LAST_BIT);
  assign hit   = (sr_nx == ma_q) || (sr_nx == mb_q);
  assign clr   = (reg_wr && reg_addr == A_STAT) ? reg_wdata[1:0] : 2'b00;
  assign set   = {done && hit, done};
  assign irq_n = ~|(stat_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      hold_q <= '0;
      cnt_q  <= '0;
      ones_q <= '0;
    end else if (bit_vld) begin
      if (drop) begin
        ones_q <= '0;
      end else begin
        sr_q  <= sr_nx;
        cnt_q <= done ? '0 : cnt_q + 1'b1;
        if (!bit_in)               ones_q <= '0;
        else if (ones_q != RUN_CAP) ones_q <= ones_q + 1'b1;
        if (done) hold_q <= sr_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma_q   <= '0;
      mb_q   <= '0;
      dstf_q <= 1'b0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_MA)   ma_q   <= reg_wdata;
      if (reg_wr && reg_addr == A_MB)   mb_q   <= reg_wdata;
      if (reg_wr && reg_addr == A_CTRL) dstf_q <= reg_wdata[0];
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[1:0];
      stat_q <= (stat_q & ~clr) | set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA:  reg_rdata = hold_q;
      A_MA:    reg_rdata = ma_q;
      A_MB:    reg_rdata = mb_q;
      A_CTRL:  reg_rdata[0] = dstf_q;
      A_MASK:  reg_rdata[1:0] = mask_q;
      A_STAT:  reg_rdata[1:0] = stat_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_FULL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !drop && cnt_q == LAST_BIT) |=> stat_q[0]); // R2
  AST_MATCH_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[1]) |-> $past(bit_vld)); // R4
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & mask_q)) |-> !irq_n); // R5
  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & mask_q)) |-> irq_n); // R5
  AST_STUFF_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && dstf_q && ones_q == RUN_AT && !bit_in) |=> ($stable(cnt_q) && $stable(sr_q))); // R6
  AST_ONES_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= RUN_CAP); // R7
  AST_W1C_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata[0] && !(bit_vld && !drop && cnt_q == LAST_BIT)) |=> !stat_q[0]); // R9
endmodule

// File: tb/dl_rx_collector_test.sv
`timescale 1ns/1ps
module dl_rx_collector_test;
  logic       clk = 0, rst_n = 0, bit_in = 0, bit_vld = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       irq_n;
  int total = 0, bad = 0;

  logic [7:0] m_sr, m_hold, m_ma, m_mb;
  int         m_cnt, m_ones;
  logic       m_dstf;
  logic [1:0] m_mask, m_stat;

  dl_rx_collector uut (.clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n));

  always #2.5 clk = ~clk;

  function automatic logic exp_irq();
    return !(|(m_stat & m_mask));
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic m_reset();
    m_sr = 0; m_hold = 0; m_ma = 0; m_mb = 0; m_cnt = 0; m_ones = 0;
    m_dstf = 0; m_mask = 0; m_stat = 0;
  endtask

  task automatic m_bit(logic b, logic [1:0] clrw);
    logic [1:0] s;
    s = 0;
    if (m_dstf && m_ones == 5 && !b) m_ones = 0;
    else begin
      m_ones = b ? ((m_ones == 6) ? 6 : m_ones + 1) : 0;
      m_sr = {b, m_sr[7:1]};
      if (m_cnt == 7) begin
        m_cnt = 0; m_hold = m_sr; s[0] = 1;
        if (m_sr == m_ma || m_sr == m_mb) s[1] = 1;
      end else m_cnt++;
    end
    m_stat = (m_stat & ~clrw) | s;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bit_vld = 0; reg_wr = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    m_reset();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    if (a == 1) m_ma = d;
    if (a == 2) m_mb = d;
    if (a == 3) m_dstf = d[0];
    if (a == 4) m_mask = d[1:0];
    if (a == 5) m_stat = m_stat & ~d[1:0];
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #0.5; v = reg_rdata;
  endtask

  task automatic send(logic b, logic w1c, logic [1:0] clrw);
    @(negedge clk); bit_in = b; bit_vld = 1;
    if (w1c) begin reg_addr = 5; reg_wdata = {6'b0, clrw}; reg_wr = 1; end
    @(negedge clk); bit_vld = 0; reg_wr = 0;
    m_bit(b, w1c ? clrw : 2'b00);
  endtask

  task automatic send_seq(logic [31:0] bits, int n);
    for (int i = 0; i < n; i++) send(bits[i], 0, 2'b00);
  endtask

  task automatic chk_all(string req);
    logic [7:0] v;
    rd(0, v); chk(req, v, m_hold);
    rd(5, v); chk(req, v, {6'b0, m_stat});
    total++;
    if (irq_n !== exp_irq()) begin
      bad++; $display("FAIL R5 irq_n got=%b exp=%b", irq_n, exp_irq());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    m_reset();
    do_reset();
    // R10 reset state
    rd(0, v); chk("R10 data", v, 8'h00);
    rd(5, v); chk("R10 status", v, 8'h00);
    chk("R10 irq_n", {7'b0, irq_n}, 8'h01);
    // R11 read-back
    wr(1, 8'h3c); wr(2, 8'h81); wr(3, 8'h01); wr(4, 8'h03);
    rd(1, v); chk("R11 ma", v, 8'h3c);
    rd(2, v); chk("R11 mb", v, 8'h81);
    rd(3, v); chk("R11 ctrl", v, 8'h01);
    rd(4, v); chk("R11 mask", v, 8'h03);
    rd(6, v); chk("R11 unused", v, 8'h00);
    // R1 bit order, R2 full flag
    do_reset();
    send_seq(32'h0000_00a5, 7);
    rd(5, v); chk("R2 not yet full", v, 8'h00);
    send_seq(32'h1, 1);
    rd(0, v); chk("R1 byte order", v, 8'ha5);
    rd(5, v); chk("R2 full", v, 8'h01);
    // R3 overwrite
    send_seq(32'h0000_005a, 8);
    rd(0, v); chk("R3 overwrite", v, 8'h5a);
    // R4 match A, B, miss
    do_reset(); wr(1, 8'h3c); wr(2, 8'h81);
    send_seq(32'h3c, 8); rd(5, v); chk("R4 match A", v, 8'h03);
    wr(5, 8'h02); rd(5, v); chk("R9 clear match only", v, 8'h01);
    send_seq(32'h81, 8); rd(5, v); chk("R4 match B", v, 8'h03);
    wr(5, 8'h03); send_seq(32'h55, 8); rd(5, v); chk("R4 no match", v, 8'h01);
    // R5 masks
    chk("R5 masked off", {7'b0, irq_n}, 8'h01);
    wr(4, 8'h01); chk("R5 full enabled", {7'b0, irq_n}, 8'h00);
    wr(5, 8'h01); chk("R5 cleared", {7'b0, irq_n}, 8'h01);
    wr(4, 8'h02); send_seq(32'h3c, 8); chk("R5 match enabled", {7'b0, irq_n}, 8'h00);
    // R9 set wins over clear
    do_reset(); send_seq(32'h7f, 7); send(1'b0, 1, 2'b01);
    rd(5, v); chk("R9 set wins", v, 8'h01);
    // R6 stuffed zero dropped: 1,1,1,1,1,(0),0,1,1
    do_reset(); wr(3, 8'h01);
    send_seq(32'b0_1111_1111_1111_1111_1111_1111 & 32'h1f, 5);
    send(1'b0, 0, 2'b00); send(1'b0, 0, 2'b00); send(1'b1, 0, 2'b00);
    rd(5, v); chk("R6 stuffed zero not counted", v, 8'h00);
    send(1'b1, 0, 2'b00);
    rd(0, v); chk("R6 destuffed byte", v, 8'hdf);
    // R7 six ones then zero kept
    do_reset(); wr(3, 8'h01);
    send_seq(32'b1011_1111, 8);
    rd(0, v); chk("R7 long run kept", v, 8'hbf);
    rd(5, v); chk("R7 full after 8", v, 8'h01);
    // R8 destuff disabled
    do_reset();
    send_seq(32'b1101_1111, 8);
    rd(0, v); chk("R8 zero kept", v, 8'hdf);
    // Random stream against model (R1 R2 R3 R4 R6 R7 R9)
    do_reset(); wr(4, 8'h03);
    for (int i = 0; i < 4000; i++) begin
      logic b, w;
      logic [1:0] c;
      if (i % 500 == 0) wr(3, {7'b0, 1'($urandom_range(0, 1))});
      if (i % 300 == 0) begin wr(1, 8'($urandom)); wr(2, 8'h7e); end
      b = ($urandom_range(0, 9) < 7);
      w = ($urandom_range(0, 19) == 0);
      c = 2'($urandom);
      send(b, w, c);
      if (i % 4 == 0) chk_all("R1 R2 R4 R6 R7 R9 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule